// File: doc/BRIEF.md
# I2C Byte-Addressed Memory Target

This block is a bus target for a two-wire I2C link that fronts a byte-wide storage array behind a 15-bit location pointer. The bus clock and data lines enter as plain inputs, and the data line is driven through a single open-drain enable that pulls it low. The block never drives the clock line. The address of the target is a fixed four-bit type nibble followed by three strap inputs, so up to eight of them can sit on one pair of wires.

A transaction opens with a START and an address byte. On a write, two pointer bytes follow, high byte first. Every later byte is stored at the pointer, which then steps forward. A read either follows a repeated START after the pointer bytes, or picks up at wherever the pointer was left. Each store is committed on the clock edge that delivers the byte's last bit. The target therefore has no busy window and always answers its own address.

Both lines are brought into the system clock domain by a synchronizer chain. All bus events are decoded from the synchronized copies. The number of storage bits that are physically present is a parameter; the pointer always keeps 15 bits.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset the data-line pull-down enable `sda_oe_o` is low, and it stays low until a matching address byte arrives.
- R2: SDA falling while SCL is high is START. SDA rising while SCL is high is STOP. A START at any point, including a repeated one, restarts the address phase. A STOP releases SDA and returns the target to idle.
- R3: The address byte is {4'b1010, strap_i[2], strap_i[1], strap_i[0], rw}, sent MSB first, with rw = 1 meaning read. On a match the target pulls SDA low for the ninth clock. On any mismatch it gives no acknowledge and ignores the rest of the transfer until the next START.
- R4: When rw = 0, the next two bytes load the pointer, high byte first. Each later byte is stored at the pointer. Every one of these bytes is acknowledged, and a store happens only while the target is not driving SDA.
- R5: Bit 15 of the received pointer is discarded, so pointer 0x8000|a selects the same location as a.
- R6: The pointer advances by one after each stored or sent byte and wraps from 0x7FFF to 0x0000.
- R7: Pointer bytes, then a repeated START, then an address byte with rw = 1 starts a read at the loaded location.
- R8: A read that begins without new pointer bytes continues from the pointer left by the previous transfer.
- R9: Read data leaves MSB first. SDA is released during the master's acknowledge clock, and the pull-down is only switched on while SCL is low.
- R10: After the master does not acknowledge a read byte, the target drives nothing until the next START or STOP, even if SCL keeps toggling.
- R11: A new transfer that starts right after a write's STOP has its address acknowledged. There is no busy or polling period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | When high, pull the data line low |
| strap_i | input | 3 | Device select straps forming address bits 3..1 |

## Verification
The assertions are checked on every cycle. They confirm that the pull-down only turns on in a cycle where synchronized SCL was low, and that every START or STOP leaves SDA released. They also confirm that no store happens while the target drives the line, and that each store advances the pointer by exactly one modulo 2^15. Other behaviours can only be shown by the bench's directed transfers at the pins: address matching against the straps, the order of pointer bytes, discarding of the top pointer bit, wrap-around, random versus current reads, silence after a master NACK, and the absence of a busy period.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

   localparam int BYTE_W = 8;

   // Protocol engine phases
   typedef enum logic [3:0] {
      ST_IDLE,     // no transfer addressed to us
      ST_DEV,      // shifting in the address byte
      ST_ADR_HI,   // shifting in pointer high byte
      ST_ADR_LO,   // shifting in pointer low byte
      ST_WR,       // shifting in a data byte to store
      ST_ACK,      // holding SDA low for the ninth clock
      ST_RD,       // shifting a data byte out
      ST_MACK,     // listening to the master's acknowledge
      ST_WAIT      // off the bus until START or STOP
   } phase_t;

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   localparam int TOP = SYNC_STAGES - 1;

   // Bit 1 is SCL, bit 0 is SDA, both travelling the same chain
   logic [SYNC_STAGES-1:0][1:0] pipe;
   logic                        scl_q;
   logic                        sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe  <= '1;
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         pipe  <= {pipe[SYNC_STAGES-2:0], {scl_i, sda_i}};
         scl_q <= pipe[TOP][1];
         sda_q <= pipe[TOP][0];
      end
   end

   assign scl_s     = pipe[TOP][1];
   assign sda_s     = pipe[TOP][0];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   // Data line moving while clock stays high marks a bus condition
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
   parameter int ARRAY_AW = 11,
   parameter int DATA_W   = 8
) (
   input  logic                clk,
   input  logic                we,
   input  logic [ARRAY_AW-1:0] idx,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata
);

   localparam int DEPTH = 1 << ARRAY_AW;

   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         store[idx] <= wdata;
      end
   end

   // Read path is combinational so a byte is ready the moment it is needed
   assign rdata = store[idx];

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
   import i2c_mem_pkg::*;
#(
   parameter int           MEM_AW   = 15,
   parameter logic [3:0]   DEV_TYPE = 4'b1010
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sda_s,
   input  logic               scl_rise,
   input  logic               scl_fall,
   input  logic               start_det,
   input  logic               stop_det,
   input  logic [2:0]         strap_i,
   input  logic [BYTE_W-1:0]  rd_data,
   output logic               sda_oe,
   output logic               mem_we,
   output logic [BYTE_W-1:0]  wr_data,
   output logic [MEM_AW-1:0]  ptr
);

   localparam int HI_W = MEM_AW - BYTE_W;

   phase_t            phase;
   phase_t            after_ack;
   logic [3:0]        bit_cnt;
   logic [BYTE_W-1:0] rx;
   logic [BYTE_W-1:0] tx;
   logic              mack_ok;
   logic              dev_hit;

   assign dev_hit = (rx[7:1] == {DEV_TYPE, strap_i});

   // Store fires on the rising edge carrying the eighth bit of a data byte
   assign mem_we  = (phase == ST_WR) && scl_rise && (bit_cnt == 4'd7);
   assign wr_data = {rx[6:0], sda_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= ST_IDLE;
         after_ack <= ST_IDLE;
         bit_cnt   <= '0;
         rx        <= '0;
         tx        <= '0;
         mack_ok   <= 1'b0;
         sda_oe    <= 1'b0;
         ptr       <= '0;
      end else if (start_det) begin
         phase   <= ST_DEV;
         bit_cnt <= '0;
         sda_oe  <= 1'b0;
      end else if (stop_det) begin
         phase   <= ST_IDLE;
         bit_cnt <= '0;
         sda_oe  <= 1'b0;
      end else begin
         if (mem_we) begin
            ptr <= ptr + 1'b1;
         end

         if (scl_rise) begin
            unique case (phase)
               ST_DEV, ST_ADR_HI, ST_ADR_LO, ST_WR: begin
                  if (bit_cnt != 4'd8) begin
                     rx      <= {rx[6:0], sda_s};
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
               ST_RD:   bit_cnt <= bit_cnt + 1'b1;
               ST_MACK: mack_ok <= ~sda_s;
               default: ;
            endcase
         end

         if (scl_fall) begin
            unique case (phase)
               ST_DEV: begin
                  if (bit_cnt == 4'd8) begin
                     if (dev_hit) begin
                        after_ack <= rx[0] ? ST_RD : ST_ADR_HI;
                        phase     <= ST_ACK;
                        sda_oe    <= 1'b1;
                     end else begin
                        phase <= ST_WAIT;
                     end
                  end
               end
               ST_ADR_HI: begin
                  if (bit_cnt == 4'd8) begin
                     ptr[MEM_AW-1:BYTE_W] <= rx[HI_W-1:0];
                     after_ack            <= ST_ADR_LO;
                     phase                <= ST_ACK;
                     sda_oe               <= 1'b1;
                  end
               end
               ST_ADR_LO: begin
                  if (bit_cnt == 4'd8) begin
                     ptr[BYTE_W-1:0] <= rx;
                     after_ack       <= ST_WR;
                     phase           <= ST_ACK;
                     sda_oe          <= 1'b1;
                  end
               end
               ST_WR: begin
                  if (bit_cnt == 4'd8) begin
                     after_ack <= ST_WR;
                     phase     <= ST_ACK;
                     sda_oe    <= 1'b1;
                  end
               end
               ST_ACK: begin
                  bit_cnt <= '0;
                  phase   <= after_ack;
                  if (after_ack == ST_RD) begin
                     tx     <= rd_data;
                     sda_oe <= ~rd_data[7];
                     ptr    <= ptr + 1'b1;
                  end else begin
                     sda_oe <= 1'b0;
                  end
               end
               ST_RD: begin
                  if (bit_cnt == 4'd8) begin
                     sda_oe <= 1'b0;
                     phase  <= ST_MACK;
                  end else begin
                     tx     <= {tx[6:0], 1'b0};
                     sda_oe <= ~tx[6];
                  end
               end
               ST_MACK: begin
                  if (mack_ok) begin
                     tx      <= rd_data;
                     sda_oe  <= ~rd_data[7];
                     ptr     <= ptr + 1'b1;
                     bit_cnt <= '0;
                     phase   <= ST_RD;
                  end else begin
                     phase <= ST_WAIT;
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
   parameter int         MEM_AW      = 15,
   parameter int         ARRAY_AW    = 11,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] DEV_TYPE    = 4'b1010
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe_o,
   input  logic [2:0] strap_i
);

   localparam int DW = i2c_mem_pkg::BYTE_W;

   // Parameter sanity, caught at elaboration
   if (MEM_AW < 9 || MEM_AW > 16) begin : g_bad_mem_aw
      $error("MEM_AW must lie in 9..16");
   end
   if (ARRAY_AW < 1 || ARRAY_AW > MEM_AW) begin : g_bad_array_aw
      $error("ARRAY_AW must lie in 1..MEM_AW");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic              scl_s;
   logic              sda_s;
   logic              scl_rise;
   logic              scl_fall;
   logic              start_det;
   logic              stop_det;
   logic              mem_we;
   logic [DW-1:0]     wr_data;
   logic [DW-1:0]     rd_data;
   logic [MEM_AW-1:0] ptr;
   logic [ARRAY_AW-1:0] arr_idx;

   i2c_bus_sync #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_slave_fsm #(
      .MEM_AW   (MEM_AW),
      .DEV_TYPE (DEV_TYPE)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .strap_i   (strap_i),
      .rd_data   (rd_data),
      .sda_oe    (sda_oe_o),
      .mem_we    (mem_we),
      .wr_data   (wr_data),
      .ptr       (ptr)
   );

   // Full-depth storage uses the whole pointer; a reduced one aliases on low bits
   if (ARRAY_AW == MEM_AW) begin : g_full_depth
      assign arr_idx = ptr;
   end else begin : g_partial_depth
      assign arr_idx = ptr[ARRAY_AW-1:0];
   end

   i2c_mem_array #(
      .ARRAY_AW (ARRAY_AW),
      .DATA_W   (DW)
   ) u_array (
      .clk   (clk),
      .we    (mem_we),
      .idx   (arr_idx),
      .wdata (wr_data),
      .rdata (rd_data)
   );

endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk #(
   parameter int MEM_AW = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_s,
   input logic              start_det,
   input logic              stop_det,
   input logic              mem_we,
   input logic [MEM_AW-1:0] ptr,
   input logic              sda_oe_o
);

   AST_BUS_COND_RELEASE_START: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sda_oe_o);                                   // R2

   AST_BUS_COND_RELEASE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe_o);                                    // R2

   AST_STORE_WHILE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !sda_oe_o);                                      // R4

   AST_PTR_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (ptr == MEM_AW'($past(ptr) + 1'b1)));            // R6

   AST_PULLDOWN_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> !$past(scl_s));                         // R9

endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(
   .MEM_AW (MEM_AW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_s     (scl_s),
   .start_det (start_det),
   .stop_det  (stop_det),
   .mem_we    (mem_we),
   .ptr       (ptr),
   .sda_oe_o  (sda_oe_o)
);

// File: tb/i2c_mem_slave_tb.sv
module i2c_mem_slave_tb;

   localparam int       CLK_PERIOD = 10;
   localparam int       QTR        = 5;          // system clocks per quarter bus bit
   localparam logic [2:0] STRAP    = 3'b101;
   localparam logic [6:0] DEV      = {4'b1010, STRAP};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe;
   logic sda_line;
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   i2c_mem_slave u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_m),
      .sda_i    (sda_line),
      .sda_oe_o (sda_oe),
      .strap_i  (STRAP)
   );

   task automatic q();
      repeat (QTR) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic m_start();
      q(); sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0;
   endtask

   task automatic m_stop();
      q(); sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
   endtask

   task automatic m_wr(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         q(); sda_m = b[i]; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0;
      end
      q(); sda_m = 1'b1; q(); scl_m = 1'b1; q(); ack = ~sda_line; q(); scl_m = 1'b0;
   endtask

   task automatic m_rd(input logic nack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         q(); q(); scl_m = 1'b1; q(); b[i] = sda_line; q(); scl_m = 1'b0;
      end
      q(); sda_m = nack; q(); scl_m = 1'b1; q();
      chk("R9 released in master ack clock", {15'd0, sda_oe}, 16'd0);
      q(); scl_m = 1'b0;
      q(); sda_m = 1'b1;
   endtask

   // START, address byte with write, two pointer bytes; all acks checked
   task automatic set_ptr(input logic [15:0] a);
      logic ack;
      m_start();
      m_wr({DEV, 1'b0}, ack); chk("R3 address ack", {15'd0, ack}, 16'd1);
      m_wr(a[15:8], ack);     chk("R4 pointer high ack", {15'd0, ack}, 16'd1);
      m_wr(a[7:0], ack);      chk("R4 pointer low ack", {15'd0, ack}, 16'd1);
   endtask

   task automatic t_write_burst();
      logic ack;
      set_ptr(16'h0123);
      for (int k = 0; k < 4; k++) begin
         m_wr(8'h81 + 8'(k * 17), ack);
         chk("R4 data ack", {15'd0, ack}, 16'd1);
      end
      m_stop();
      chk("R2 released after STOP", {15'd0, sda_oe}, 16'd0);
   endtask

   task automatic t_random_then_current();
      logic ack;
      logic [7:0] d;
      // R11: address answered straight after the write's STOP
      set_ptr(16'h0123);
      m_start();
      m_wr({DEV, 1'b1}, ack); chk("R7 read address ack", {15'd0, ack}, 16'd1);
      for (int k = 0; k < 3; k++) begin
         m_rd(k == 2, d);
         chk("R7 random read data MSB first", {8'd0, d}, {8'd0, 8'h81 + 8'(k * 17)});
      end
      m_stop();
      m_start();
      m_wr({DEV, 1'b1}, ack); chk("R8 current read ack", {15'd0, ack}, 16'd1);
      m_rd(1'b1, d);
      chk("R8 current read continues", {8'd0, d}, 16'h00B4);
      m_stop();
   endtask

   task automatic t_no_busy();
      logic ack;
      set_ptr(16'h0200);
      m_wr(8'h3C, ack);
      m_stop();
      m_start();
      m_wr({DEV, 1'b0}, ack);
      chk("R11 address acked right after write", {15'd0, ack}, 16'd1);
      m_stop();
   endtask

   task automatic t_mismatch();
      logic ack;
      m_start();
      m_wr({4'b1010, 3'b000, 1'b0}, ack);
      chk("R3 strap mismatch not acked", {15'd0, ack}, 16'd0);
      m_wr(8'h00, ack);
      chk("R3 bytes after mismatch ignored", {15'd0, ack}, 16'd0);
      m_stop();
      m_start();
      m_wr({4'b1011, STRAP, 1'b0}, ack);
      chk("R3 type mismatch not acked", {15'd0, ack}, 16'd0);
      m_stop();
   endtask

   task automatic t_top_bit();
      logic ack;
      logic [7:0] d;
      set_ptr(16'h8040);
      m_wr(8'h5A, ack);
      m_stop();
      set_ptr(16'h0040);
      m_start();
      m_wr({DEV, 1'b1}, ack);
      m_rd(1'b1, d);
      chk("R5 top pointer bit discarded", {8'd0, d}, 16'h005A);
      m_stop();
   endtask

   task automatic t_wrap();
      logic ack;
      logic [7:0] d;
      set_ptr(16'h7FFF);
      m_wr(8'hA1, ack);
      m_wr(8'hA2, ack);
      m_stop();
      set_ptr(16'h0000);
      m_start();
      m_wr({DEV, 1'b1}, ack);
      m_rd(1'b1, d);
      chk("R6 second byte wrapped to 0x0000", {8'd0, d}, 16'h00A2);
      m_stop();
      set_ptr(16'h7FFF);
      m_start();
      m_wr({DEV, 1'b1}, ack);
      m_rd(1'b0, d);
      chk("R6 byte at 0x7FFF", {8'd0, d}, 16'h00A1);
      m_rd(1'b1, d);
      chk("R6 read wraps to 0x0000", {8'd0, d}, 16'h00A2);
      m_stop();
   endtask

   task automatic t_nack_silence();
      logic ack;
      logic [7:0] d;
      set_ptr(16'h0200);
      m_start();
      m_wr({DEV, 1'b1}, ack);
      m_rd(1'b1, d);
      chk("R9 read data", {8'd0, d}, 16'h003C);
      m_rd(1'b1, d);
      chk("R10 silent after master NACK", {8'd0, d}, 16'h00FF);
      m_stop();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not complete");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      chk("R1 released in reset", {15'd0, sda_oe}, 16'd0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R1 released after reset", {15'd0, sda_oe}, 16'd0);
      t_write_burst();
      t_random_then_current();
      t_no_busy();
      t_mismatch();
      t_top_bit();
      t_wrap();
      t_nack_silence();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule